// File: doc/BRIEF.md
# DMA Completion Interrupt Aggregator

This block holds one 32-bit control and status word that collects the end-of-transfer events of up to seven DMA channels into a single interrupt request for the main interrupt controller. Software writes the configuration fields, the per-channel enables and the global enable, and acknowledges a channel by writing a one to that channel's flag. A bus-error input, or software setting the same bit, forces the interrupt condition on.

A summary flag in the top bit shows whether an interrupt condition exists at the moment. The request sent onward is an edge, not a level: one clock of `irq_pulse` each time the summary flag goes from clear to set. A condition that stays set without a break does not raise a second request. Software has to drop the condition, for example by clearing every pending flag, before a new request can be sent.

Field positions: bits 5:0 hold general configuration, bit 15 is the force/bus-error bit, bits 22:16 are the channel enables (channel n at 16+n), bit 23 is the global enable, bits 30:24 are the channel flags (channel n at 24+n), and bit 31 is the summary flag. Bits 14:6 are reserved.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After a synchronous reset, `rd_data` is 0 and `irq_pulse` is 0.
- R2: A write loads bits 5:0, 15, 22:16 and 23 from `wr_data`, which is write mask 0x00FF803F. Bits 14:6 always read 0.
- R3: On a write, each flag bit 24+n written as 1 is cleared, and each written as 0 keeps its value.
- R4: A pulse on `done_strobe[n]` sets flag 24+n only if enable bit 16+n, as held in the register at that clock edge, is 1. Otherwise the pulse has no effect.
- R5: If a write clears flag 24+n in the same cycle that an enabled strobe sets it, the flag ends up set.
- R6: Bit 31 reads 1 exactly when (bit 23 is 1 and any of bits 30:24 is 1) or bit 15 is 1. Otherwise it reads 0.
- R7: `irq_pulse` is 1 for exactly the one cycle after a clock edge at which bit 31 goes from 0 to 1. It stays 0 while bit 31 remains 1.
- R8: A 1 on `bus_err` sets bit 15. The bit stays set until a write puts 0 there. If a write and `bus_err` fall in the same cycle, bit 15 ends up set.
- R9: The value written to bit 31 has no effect on the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write value |
| done_strobe | input | 7 | Per-channel transfer-complete pulses |
| bus_err | input | 1 | Bus-error event, sets the force bit |
| rd_data | output | 32 | Current register value |
| irq_pulse | output | 1 | One-cycle request to the main interrupt controller |

## Verification
A software write can fall in the same clock as a channel's completion strobe or a bus error. The write may clear a flag that the strobe sets, or put 0 on the force bit that the error sets. The bench provokes these collisions on every channel, and also in a long pseudo-random stream that mixes writes, strobes and errors. An arithmetic model computes the register and the edge-detected request after each edge, and the outputs are compared with it. Collisions that drop the summary flag and raise it again are judged on whether exactly one new request appears.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned CFG_W     = 6;
  localparam int unsigned FORCE_BIT = 15;
  localparam int unsigned EN_LSB    = 16;
  localparam int unsigned GEN_BIT   = 23;
  localparam int unsigned FLG_LSB   = 24;
  localparam int unsigned SUM_BIT   = 31;
  localparam int unsigned MAX_CH    = 7;
endpackage

// File: rtl/dmairq_cfg_reg.sv
module dmairq_cfg_reg
  import dmairq_pkg::*;
#(
  parameter int unsigned NCH = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             bus_err,
  output logic [CFG_W-1:0] cfg_o,
  output logic             force_o,
  output logic [NCH-1:0]   en_o,
  output logic             gen_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_o   <= '0;
      force_o <= 1'b0;
      en_o    <= '0;
      gen_o   <= 1'b0;
    end else begin
      if (wr_en) begin
        cfg_o <= wr_data[CFG_W-1:0];
        en_o  <= wr_data[EN_LSB +: NCH];
        gen_o <= wr_data[GEN_BIT];
      end
      if (bus_err)    force_o <= 1'b1;
      else if (wr_en) force_o <= wr_data[FORCE_BIT];
    end
  end

  // R8: an error event always leaves the force bit set
  p_berr_sets_r8: assert property (@(posedge clk) disable iff (rst)
    bus_err |=> force_o);
endmodule

// File: rtl/dmairq_flag_bank.sv
module dmairq_flag_bank #(
  parameter int unsigned NCH = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [NCH-1:0] clr_bits,
  input  logic [NCH-1:0] en_bits,
  input  logic [NCH-1:0] strobe,
  output logic [NCH-1:0] flags_o
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic set_w;
    logic clr_w;
    assign set_w = strobe[i] & en_bits[i];
    assign clr_w = wr_en & clr_bits[i];

    always_ff @(posedge clk) begin
      if (rst)        flags_o[i] <= 1'b0;
      else if (set_w) flags_o[i] <= 1'b1;
      else if (clr_w) flags_o[i] <= 1'b0;
    end

    // R4 and R5: an enabled strobe always lands, even against a clear
    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
      (strobe[i] && en_bits[i]) |=> flags_o[i]);
    // R3: a clear without a set empties the flag
    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && clr_bits[i] && !(strobe[i] && en_bits[i])) |=> !flags_o[i]);
    // R4: a disabled strobe with no write leaves the flag alone
    p_gated_r4: assert property (@(posedge clk) disable iff (rst)
      (!wr_en && !(strobe[i] && en_bits[i])) |=> $stable(flags_o[i]));
  end
endmodule

// File: rtl/dmairq_summary.sv
module dmairq_summary #(
  parameter int unsigned NCH = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           gen,
  input  logic           force_bit,
  input  logic [NCH-1:0] flags,
  output logic           sum_o,
  output logic           irq_o
);
  logic sum_prev_q;

  assign sum_o = (gen & (|flags)) | force_bit;

  always_ff @(posedge clk) begin
    if (rst) sum_prev_q <= 1'b0;
    else     sum_prev_q <= sum_o;
  end

  assign irq_o = sum_o & ~sum_prev_q;

  // R7: the request never lasts more than one cycle
  p_pulse_single_r7: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);
  // R7: a held condition raises no further request
  p_no_repeat_r7: assert property (@(posedge clk) disable iff (rst)
    (sum_o && $past(sum_o)) |-> !irq_o);
  // R7: a request only accompanies a set summary flag
  p_pulse_with_sum_r7: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> sum_o);
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dmairq_pkg::*;
#(
  parameter int unsigned NCH = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [NCH-1:0]   done_strobe,
  input  logic             bus_err,
  output logic [REG_W-1:0] rd_data,
  output logic             irq_pulse
);
  localparam int unsigned SPARE = MAX_CH - NCH;

  logic [CFG_W-1:0] cfg;
  logic             force_bit;
  logic [NCH-1:0]   en;
  logic             gen;
  logic [NCH-1:0]   flags;
  logic             sum;

  dmairq_cfg_reg #(.NCH(NCH)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .bus_err(bus_err), .cfg_o(cfg), .force_o(force_bit),
    .en_o(en), .gen_o(gen)
  );

  dmairq_flag_bank #(.NCH(NCH)) u_flags (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .clr_bits(wr_data[FLG_LSB +: NCH]), .en_bits(en),
    .strobe(done_strobe), .flags_o(flags)
  );

  dmairq_summary #(.NCH(NCH)) u_sum (
    .clk(clk), .rst(rst), .gen(gen), .force_bit(force_bit),
    .flags(flags), .sum_o(sum), .irq_o(irq_pulse)
  );

  always_comb begin
    rd_data = '0;
    rd_data[CFG_W-1:0]     = cfg;
    rd_data[FORCE_BIT]     = force_bit;
    rd_data[EN_LSB +: NCH] = en;
    rd_data[GEN_BIT]       = gen;
    rd_data[FLG_LSB +: NCH] = flags;
    rd_data[SUM_BIT]       = sum;
  end

  initial begin
    if (NCH < 1 || NCH > MAX_CH || SPARE > MAX_CH)
      $error("dma_irq_ctrl: NCH out of range");
  end

  // R2: reserved field stays zero
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    rd_data[14:6] == '0);
  // R6: summary bit agrees with the stored fields
  p_sum_r6: assert property (@(posedge clk) disable iff (rst)
    rd_data[SUM_BIT] == ((rd_data[GEN_BIT] && (|rd_data[30:24])) || rd_data[FORCE_BIT]));
  // R1: idle outputs while in reset
  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (rd_data == '0 && !irq_pulse));
endmodule

// File: tb/dma_irq_ctrl_tb.sv
`timescale 1ns/1ps
module dma_irq_ctrl_tb;
  localparam int NCH = 7;
  localparam logic [31:0] WMASK = 32'h00FF803F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [NCH-1:0] done_strobe = '0;
  logic        bus_err = 1'b0;
  logic [31:0] rd_data;
  logic        irq_pulse;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [31:0] model = '0;
  logic        exp_irq = 1'b0;
  logic [31:0] lfsr = 32'hACE1_1234;

  always #2.5 clk = ~clk;

  dma_irq_ctrl #(.NCH(NCH)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .done_strobe(done_strobe), .bus_err(bus_err),
    .rd_data(rd_data), .irq_pulse(irq_pulse)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // apply one cycle of stimulus, update model, compare after the edge
  task automatic step(input logic w, input logic [31:0] d, input logic [NCH-1:0] s,
                      input logic be, input string tag);
    logic [31:0] nx;
    logic [NCH-1:0] setm;
    logic sum;
    @(negedge clk);
    wr_en = w; wr_data = d; done_strobe = s; bus_err = be;
    nx = model;
    setm = s & model[22:16];
    if (w) begin
      nx = (nx & ~WMASK) | (d & WMASK);
      nx[30:24] = model[30:24] & ~d[30:24];
    end
    nx[30:24] = nx[30:24] | setm;
    if (be) nx[15] = 1'b1;
    sum = (nx[23] && (|nx[30:24])) || nx[15];
    exp_irq = sum && !model[31];
    nx[31] = sum;
    model = nx;
    @(posedge clk); #1;
    check({tag, " reg"}, rd_data, model);
    check({tag, " irq"}, {31'b0, irq_pulse}, {31'b0, exp_irq});
    @(negedge clk);
    wr_en = 0; wr_data = '0; done_strobe = '0; bus_err = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset reg", rd_data, 32'h0);
    check("R1 reset irq", {31'b0, irq_pulse}, 32'h0);
    @(negedge clk); rst = 1'b0;

    // R2 / R9: mask sweep, bit 31 written ignored
    step(1, 32'hFFFF_FFFF, '0, 0, "R2 R9 all ones");
    step(1, 32'h0000_0000, '0, 0, "R2 zero");
    step(1, 32'h8000_7FC0, '0, 0, "R9 R2 rsvd+top");
    step(1, 32'h0000_0000, '0, 0, "R6 drop force");

    for (int n = 0; n < NCH; n++) begin
      // disabled channel: strobe ignored (R4)
      step(1, 32'h0080_0000, '0, 0, "R2 gen only");
      step(0, '0, NCH'(1) << n, 0, "R4 disabled strobe");
      // enable channel n, then strobe -> rising summary (R7)
      step(1, 32'h0080_0000 | (32'h1 << (16+n)), '0, 0, "R2 enable");
      step(0, '0, NCH'(1) << n, 0, "R4 R7 rise");
      step(0, '0, NCH'(1) << n, 0, "R7 no repeat");
      step(0, '0, '0, 0, "R7 idle");
      // collision: clear and set same flag (R5)
      step(1, 32'h0080_0000 | (32'h1 << (16+n)) | (32'h1 << (24+n)), NCH'(1) << n, 0, "R5 collision");
      // clear (R3), then write 0 keeps flag test
      step(1, 32'h0080_0000 | (32'h1 << (16+n)) | (32'h1 << (24+n)), '0, 0, "R3 clear");
      step(0, '0, NCH'(1) << n, 0, "R7 re-rise");
      step(1, 32'h0080_0000 | (32'h1 << (16+n)), '0, 0, "R3 keep on zero");
      step(1, 32'h0000_0000 | (32'h1 << (16+n)), '0, 0, "R6 gen off");
      step(1, 32'h0080_0000 | (32'h1 << (16+n)), '0, 0, "R6 R7 gen on");
      // bus error collision with write of 0 (R8)
      step(1, 32'h0000_0000 | (32'h1 << (24+n)), '0, 1, "R8 err wins");
      step(0, '0, '0, 0, "R8 sticky");
      step(1, 32'h7F00_0000, '0, 0, "R8 R3 write clears");
    end

    // pseudo-random mix of everything
    for (int k = 0; k < 600; k++) begin
      logic [31:0] d;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      d = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      step(lfsr[3] & lfsr[9], d, NCH'(lfsr[20:14]), lfsr[5] & lfsr[6] & lfsr[7], "R6 R7 mix");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule